// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit with Accumulator Interlock

This block is a four-stage multiply-accumulate engine placed behind the execute stage of an integer operand pipeline. Its first stage is that execute cycle. Each cycle the host may issue one operation on a pair of signed 32-bit operands: multiply-accumulate into an accumulator, load an accumulator from a register value, or copy one accumulator into another. There are four 48-bit accumulators. Every write takes effect when its operation leaves the fourth stage.

Operations retire in issue order, and each one reads the accumulator state at retirement. Long runs of dependent multiply-accumulates therefore issue every cycle without stalling. The integer side reads accumulators through a separate port. A per-accumulator scoreboard of writes in flight raises a stall while the selected accumulator still has a write pending. The host holds its read until the stall drops, and it then sees the final value that the program expects.

Top module: `mac_accum_unit`

## Requirements
- R1: After reset all four accumulators read as zero, and a read raises no stall.
- R2: A multiply-accumulate (op code 0) adds the low 48 bits of the signed 32x32 product to the destination accumulator. The sum wraps modulo 2^48. An operation issued in cycle t is visible to a read in cycle t+4.
- R3: A load (op code 1) writes the 32-bit operand A, sign-extended to 48 bits, into the destination accumulator.
- R4: A copy (op code 2) writes into the destination the source accumulator's value after every older operation has retired.
- R5: Operations may issue every cycle with no stall. Back-to-back operations on the same accumulator chain correctly.
- R6: A read of an accumulator with no pending write returns its value combinationally in the same cycle, and the stall stays low.
- R7: A read of an accumulator with a write issued in an earlier cycle and not yet retired raises the stall until that write retires. A read in the cycle after the issue stalls for exactly 3 cycles.
- R8: Op code 3, or an operation with the issue valid bit low, changes no accumulator and causes no stall.
- R9: The destination select travels with its operation, so only the accumulator chosen at issue changes. A pending write on one accumulator does not stall reads of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An operation is offered this cycle |
| issue_op | input | 2 | 0 multiply-accumulate, 1 load, 2 copy, 3 none |
| issue_dst | input | 2 | Destination accumulator |
| issue_src | input | 2 | Source accumulator for copy |
| issue_a | input | 32 | Signed operand A (also the load value) |
| issue_b | input | 32 | Signed operand B |
| rd_req | input | 1 | Integer side requests an accumulator |
| rd_sel | input | 2 | Accumulator to read |
| rd_data | output | 48 | Selected accumulator value, valid when no stall |
| rd_stall | output | 1 | Read must wait: selected accumulator has a write in flight |

## Verification
Directed sequences issue a single write and then hold a read on its destination. They measure the stall length and separate the no-hazard, just-issued and long-issued cases. Back-to-back chains of multiply-accumulates, and a copy issued right behind a write to its source, show whether each operation sees the accumulator state at retirement or a stale value. Corner operands (minimum times minimum, products above 2^47, negative loads) and no-op or invalid issues test the 48-bit wrap and the ignore rule. A long seeded random mix of all ops, selects and reads is compared every cycle against a model that updates only at retirement.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int MAC_STAGES = 4;

    typedef enum logic [1:0] {
        OP_MAC  = 2'd0,
        OP_LOAD = 2'd1,
        OP_COPY = 2'd2,
        OP_NONE = 2'd3
    } mac_op_e;
endpackage

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int OPW  = 32,
    parameter int ACCW = 48,
    parameter int SELW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  mac_op_e           in_op,
    input  logic [SELW-1:0]   in_dst,
    input  logic [SELW-1:0]   in_src,
    input  logic [OPW-1:0]    in_a,
    input  logic [OPW-1:0]    in_b,
    output logic              ret_vld,
    output mac_op_e           ret_op,
    output logic [SELW-1:0]   ret_dst,
    output logic [SELW-1:0]   ret_src,
    output logic [ACCW-1:0]   ret_val
);
    typedef struct packed {
        logic            vld;
        mac_op_e         op;
        logic [SELW-1:0] dst;
        logic [SELW-1:0] src;
        logic [OPW-1:0]  a;
        logic [OPW-1:0]  b;
    } opnd_t;

    typedef struct packed {
        logic            vld;
        mac_op_e         op;
        logic [SELW-1:0] dst;
        logic [SELW-1:0] src;
        logic [ACCW-1:0] val;
    } res_t;

    typedef struct packed {
        opnd_t s2;
        res_t  s3;
        res_t  s4;
    } pipe_t;

    pipe_t st_d, st_q;
    logic [ACCW-1:0] mul_a, mul_b, prod;

    function automatic logic [ACCW-1:0] sext(input logic [OPW-1:0] v);
        return {{(ACCW-OPW){v[OPW-1]}}, v};
    endfunction

    // Low ACCW bits of the widened product equal those of the full product.
    always_comb begin
        st_d    = st_q;
        st_d.s2 = '{vld: in_vld, op: in_op, dst: in_dst, src: in_src, a: in_a, b: in_b};

        mul_a = sext(st_q.s2.a);
        mul_b = sext(st_q.s2.b);
        prod  = mul_a * mul_b;

        st_d.s3.vld = st_q.s2.vld;
        st_d.s3.op  = st_q.s2.op;
        st_d.s3.dst = st_q.s2.dst;
        st_d.s3.src = st_q.s2.src;
        st_d.s3.val = (st_q.s2.op == OP_MAC) ? prod : mul_a;

        st_d.s4 = st_q.s3;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ret_vld = st_q.s4.vld;
    assign ret_op  = st_q.s4.op;
    assign ret_dst = st_q.s4.dst;
    assign ret_src = st_q.s4.src;
    assign ret_val = st_q.s4.val;

    AST_RETIRE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ##2 ret_vld); // R2
endmodule

// File: rtl/mac_scoreboard.sv
module mac_scoreboard
    import mac_pkg::*;
#(
    parameter int NACC = 4,
    parameter int SELW = 2,
    parameter int CNTW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [SELW-1:0]   issue_dst,
    input  logic              ret_vld,
    input  logic [SELW-1:0]   ret_dst,
    output logic [NACC-1:0]   busy
);
    typedef struct packed {
        logic [NACC-1:0][CNTW-1:0] cnt;
    } sb_t;

    sb_t sb_d, sb_q;

    always_comb begin
        sb_d = sb_q;
        for (int k = 0; k < NACC; k++) begin
            sb_d.cnt[k] = sb_q.cnt[k]
                        + CNTW'(issue_vld && (issue_dst == SELW'(k)))
                        - CNTW'(ret_vld && (ret_dst == SELW'(k)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    for (genvar g = 0; g < NACC; g++) begin : g_busy
        assign busy[g] = (sb_q.cnt[g] != '0);

        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            sb_q.cnt[g] <= CNTW'(MAC_STAGES - 1)); // R5
        AST_ISSUE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_vld && issue_dst == SELW'(g)) |=> busy[g]); // R7
    end

    AST_RETIRE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld |-> busy[ret_dst]); // R7
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank
    import mac_pkg::*;
#(
    parameter int ACCW = 48,
    parameter int NACC = 4,
    parameter int SELW = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_vld,
    input  mac_op_e                    wr_op,
    input  logic [SELW-1:0]            wr_dst,
    input  logic [SELW-1:0]            wr_src,
    input  logic [ACCW-1:0]            wr_val,
    output logic [NACC-1:0][ACCW-1:0]  acc_out
);
    typedef struct packed {
        logic [NACC-1:0][ACCW-1:0] acc;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_vld) begin
            unique case (wr_op)
                OP_MAC:  bank_d.acc[wr_dst] = bank_q.acc[wr_dst] + wr_val;
                OP_LOAD: bank_d.acc[wr_dst] = wr_val;
                OP_COPY: bank_d.acc[wr_dst] = bank_q.acc[wr_src];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign acc_out = bank_q.acc;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |=> $stable(bank_q)); // R8
endmodule

// File: rtl/mac_accum_unit.sv
module mac_accum_unit
    import mac_pkg::*;
#(
    parameter  int OPW  = 32,
    parameter  int ACCW = 48,
    parameter  int NACC = 4,
    localparam int SELW = $clog2(NACC),
    localparam int CNTW = $clog2(MAC_STAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [1:0]        issue_op,
    input  logic [SELW-1:0]   issue_dst,
    input  logic [SELW-1:0]   issue_src,
    input  logic [OPW-1:0]    issue_a,
    input  logic [OPW-1:0]    issue_b,
    input  logic              rd_req,
    input  logic [SELW-1:0]   rd_sel,
    output logic [ACCW-1:0]   rd_data,
    output logic              rd_stall
);
    mac_op_e                   in_op;
    logic                      in_vld;
    logic                      ret_vld;
    mac_op_e                   ret_op;
    logic [SELW-1:0]           ret_dst, ret_src;
    logic [ACCW-1:0]           ret_val;
    logic [NACC-1:0]           busy;
    logic [NACC-1:0][ACCW-1:0] acc_all;

    assign in_op  = mac_op_e'(issue_op);
    assign in_vld = issue_valid && (in_op != OP_NONE);

    mac_datapath #(.OPW(OPW), .ACCW(ACCW), .SELW(SELW)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_op   (in_op),
        .in_dst  (issue_dst),
        .in_src  (issue_src),
        .in_a    (issue_a),
        .in_b    (issue_b),
        .ret_vld (ret_vld),
        .ret_op  (ret_op),
        .ret_dst (ret_dst),
        .ret_src (ret_src),
        .ret_val (ret_val)
    );

    mac_scoreboard #(.NACC(NACC), .SELW(SELW), .CNTW(CNTW)) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_vld (in_vld),
        .issue_dst (issue_dst),
        .ret_vld   (ret_vld),
        .ret_dst   (ret_dst),
        .busy      (busy)
    );

    mac_acc_bank #(.ACCW(ACCW), .NACC(NACC), .SELW(SELW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_vld  (ret_vld),
        .wr_op   (ret_op),
        .wr_dst  (ret_dst),
        .wr_src  (ret_src),
        .wr_val  (ret_val),
        .acc_out (acc_all)
    );

    assign rd_data  = acc_all[rd_sel];
    assign rd_stall = rd_req && busy[rd_sel];

    AST_READ_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_stall) |-> !(ret_vld && ret_dst == rd_sel)); // R7
endmodule

// File: tb/test_mac_accum_unit.sv
module test_mac_accum_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [1:0]  issue_op = '0, issue_dst = '0, issue_src = '0;
    logic [31:0] issue_a = '0, issue_b = '0;
    logic        rd_req = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [47:0] rd_data;
    logic        rd_stall;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit last_stall;

    logic [47:0] m_acc [4];
    bit          s_v   [1:3];
    logic [1:0]  s_op  [1:3];
    logic [1:0]  s_d   [1:3];
    logic [1:0]  s_s   [1:3];
    logic [31:0] s_a   [1:3];
    logic [31:0] s_b   [1:3];

    always #5 clk = ~clk;

    mac_accum_unit i_mac_accum_unit (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_op(issue_op), .issue_dst(issue_dst),
        .issue_src(issue_src), .issue_a(issue_a), .issue_b(issue_b),
        .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data), .rd_stall(rd_stall)
    );

    function automatic int pend(input logic [1:0] k);
        int n = 0;
        for (int i = 1; i <= 3; i++) if (s_v[i] && s_d[i] == k) n++;
        return n;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: writes take effect at retirement, three edges after issue.
    task automatic model_edge();
        longint p;
        if (s_v[3]) begin
            case (s_op[3])
                2'd0: begin
                    p = longint'($signed(s_a[3])) * longint'($signed(s_b[3]));
                    m_acc[s_d[3]] = m_acc[s_d[3]] + p[47:0];
                end
                2'd1: m_acc[s_d[3]] = {{16{s_a[3][31]}}, s_a[3]};
                2'd2: m_acc[s_d[3]] = m_acc[s_s[3]];
                default: ;
            endcase
        end
        for (int i = 3; i >= 2; i--) begin
            s_v[i] = s_v[i-1]; s_op[i] = s_op[i-1]; s_d[i] = s_d[i-1];
            s_s[i] = s_s[i-1]; s_a[i] = s_a[i-1]; s_b[i] = s_b[i-1];
        end
        s_v[1] = issue_valid && (issue_op != 2'd3);
        s_op[1] = issue_op; s_d[1] = issue_dst; s_s[1] = issue_src;
        s_a[1] = issue_a; s_b[1] = issue_b;
    endtask

    task automatic cyc(input bit v, input logic [1:0] op, input logic [1:0] d,
                       input logic [1:0] s, input logic [31:0] a, input logic [31:0] b,
                       input bit rq, input logic [1:0] rs, input string tag);
        bit exp_st;
        @(posedge clk);
        model_edge();
        #1;
        issue_valid = v; issue_op = op; issue_dst = d; issue_src = s;
        issue_a = a; issue_b = b; rd_req = rq; rd_sel = rs;
        @(negedge clk);
        last_stall = rd_stall;
        if (rq) begin
            exp_st = (pend(rs) != 0);
            chk({tag, " R7 stall"}, 64'(rd_stall), 64'(exp_st));
            if (!exp_st) chk({tag, " data"}, 64'(rd_data), 64'(m_acc[rs]));
        end
    endtask

    task automatic idle();
        cyc(0, 2'd0, 2'd0, 2'd0, 32'd0, 32'd0, 0, 2'd0, "idle");
    endtask

    task automatic wait_read(input logic [1:0] sel, input string tag, input int exp_cnt);
        int cnt = 0;
        do begin
            cyc(0, 2'd0, 2'd0, 2'd0, 32'd0, 32'd0, 1, sel, tag);
            if (last_stall) cnt++;
        end while (last_stall && cnt < 12);
        chk({tag, " R7 stall cycles"}, 64'(cnt), 64'(exp_cnt));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        for (int i = 1; i <= 3; i++) begin
            s_v[i] = 0; s_op[i] = '0; s_d[i] = '0; s_s[i] = '0; s_a[i] = '0; s_b[i] = '0;
        end
        void'($urandom(32'h5eed_0042));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 4; k++) begin
            cyc(0, 2'd0, 2'd0, 2'd0, 32'd0, 32'd0, 1, 2'(k), "R1");
            chk("R1 zero", 64'(rd_data), 64'd0);
        end

        // R3 + R7: load negative value, read right after issue
        cyc(1, 2'd1, 2'd0, 2'd0, 32'hFFFF_FFFB, 32'd0, 0, 2'd0, "R3");
        wait_read(2'd0, "R3", 3);
        chk("R3 sext", 64'(rd_data), 64'hFFFF_FFFF_FFFB);

        // R6: no pending write -> no stall
        wait_read(2'd0, "R6", 0);

        // R5: back-to-back chain on acc1
        cyc(1, 2'd1, 2'd1, 2'd0, 32'hFFFF_FFFD, 32'd0, 0, 2'd0, "R5");
        cyc(1, 2'd0, 2'd1, 2'd0, 32'd7, 32'hFFFF_FFFE, 0, 2'd0, "R5");
        cyc(1, 2'd0, 2'd1, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 2'd0, "R5");
        cyc(1, 2'd0, 2'd1, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2'd0, "R5");
        wait_read(2'd1, "R5", 3);

        // R4: copy right behind a write to its source
        cyc(1, 2'd0, 2'd1, 2'd0, 32'd1000, 32'd3, 0, 2'd0, "R4");
        cyc(1, 2'd2, 2'd2, 2'd1, 32'd0, 32'd0, 0, 2'd0, "R4");
        wait_read(2'd2, "R4", 3);
        chk("R4 copy", 64'(rd_data), 64'(m_acc[1]));

        // R2: min*min product has zero low 48 bits; large product wraps
        cyc(1, 2'd1, 2'd3, 2'd0, 32'd12, 32'd0, 0, 2'd0, "R2");
        cyc(1, 2'd0, 2'd3, 2'd0, 32'h8000_0000, 32'h8000_0000, 0, 2'd0, "R2");
        wait_read(2'd3, "R2", 3);
        chk("R2 min*min", 64'(rd_data), 64'd12);
        cyc(1, 2'd0, 2'd3, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 2'd0, "R2");
        wait_read(2'd3, "R2", 3);
        chk("R2 wrap", 64'(rd_data), 64'hFFFF_0000_000D);

        // R8: op 3 and invalid issue are ignored
        cyc(1, 2'd3, 2'd2, 2'd0, 32'd55, 32'd55, 0, 2'd0, "R8");
        cyc(0, 2'd1, 2'd2, 2'd0, 32'd99, 32'd0, 1, 2'd2, "R8");
        chk("R8 no stall", 64'(last_stall), 64'd0);
        repeat (4) cyc(0, 2'd0, 2'd0, 2'd0, 32'd0, 32'd0, 1, 2'd2, "R8");
        chk("R8 unchanged", 64'(rd_data), 64'(m_acc[2]));

        // R9: pending write on acc3 does not stall others; others unchanged
        cyc(1, 2'd1, 2'd3, 2'd0, 32'd4242, 32'd0, 0, 2'd0, "R9");
        for (int k = 0; k < 3; k++) begin
            cyc(0, 2'd0, 2'd0, 2'd0, 32'd0, 32'd0, 1, 2'(k), "R9");
            chk("R9 no stall", 64'(last_stall), 64'd0);
        end
        wait_read(2'd3, "R9", 0);
        chk("R9 value", 64'(rd_data), 64'd4242);

        // Random mix against the retirement model
        for (int n = 0; n < 3000; n++) begin
            cyc(($urandom % 4) != 0, 2'($urandom), 2'($urandom), 2'($urandom),
                $urandom, $urandom, ($urandom % 2) == 1, 2'($urandom), "R2 random");
        end
        repeat (4) idle();
        for (int k = 0; k < 4; k++) wait_read(2'(k), "R9 final", 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule